// File: doc/BRIEF.md
# Dual Programmable Clock-Enable Divider

This block takes one fast reference clock and produces two clock-enable strobes from it. The fast strobe drives core logic. The slow strobe drives peripheral logic. Each strobe has its own divide ratio. Both ratios sit in one 6-bit divisor register. The fast ratio is a 2-bit power-of-two code that selects 1, 2, 4 or 8. The slow ratio is a 4-bit integer that selects 1 to 15.

Software may rewrite the divisor register at any time. There is no relock delay. A divider picks up its new ratio only at the end of the period it is running, so no strobe period is ever cut short. A slow ratio of zero is refused, and the refusal is recorded in a sticky error flag.

Each divider channel is a small state machine with two named states. In `ST_COUNT` the strobe is low and a counter advances. In `ST_PULSE` the strobe is high for one cycle.
- The transition COUNT→PULSE fires when the counter reaches ratio−2.
- The transition PULSE→COUNT fires on every period boundary where the newly loaded ratio is above 1.
- The transition PULSE→PULSE is used when the newly loaded ratio is 1, so the strobe stays high.
- On every exit from `ST_PULSE`, the channel loads its active ratio from the register.

Top module: `clkdiv_dual`

## Requirements
- R1: After reset, `rd_data` reads 6'h14 (fast code 00, slow value 5), `div_err` is 0, and `fast_en` is high on every cycle.
- R2: With slow value N (1..15) active, `slow_en` is high for exactly one cycle every N cycles. For N=1 it is high on every cycle.
- R3: Fast code in bits [1:0] maps 00→÷1, 01→÷2, 10→÷4, 11→÷8. With the ratio active, `fast_en` pulses once per that many cycles.
- R4: A write with `wr_en` high and a nonzero slow field replaces the register. Bits [1:0] hold the fast code and bits [5:2] hold the slow value. `rd_data` shows the new value on the cycle after the write edge.
- R5: A write whose bits [5:2] are 0 leaves the slow field unchanged, still takes the fast code from bits [1:0], and sets `div_err`.
- R6: Once set, `div_err` stays 1 until reset, including across later valid writes.
- R7: A ratio written in the middle of a period does not change that period. The period completes at the old length, and the following periods use the new ratio.
- R8: Changing one channel's ratio does not alter the period of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Write value: [5:2] slow value, [1:0] fast code |
| rd_data | output | 6 | Current register contents, same layout |
| div_err | output | 1 | Sticky flag for a refused zero slow value |
| fast_en | output | 1 | Core clock enable strobe |
| slow_en | output | 1 | Peripheral clock enable strobe |

## Verification
The slow channel is tried with ratios 2, 6, 10, 15 and 1.
- The even and odd values show whether the counter terminal value is off by one.
- The value 15 exercises the full counter range.
- The value 1 exercises the self-loop in `ST_PULSE`.

The fast channel is stepped through all four codes, which separates a correct decode from a linear or reversed one.

Some writes land in the middle of a long period. These show whether the running period is preserved or cut short.

A write with a zero slow field, followed by a valid write, tells a sticky flag apart from one that clears itself.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int FAST_CODE_W = 2;
    localparam int SLOW_CODE_W = 4;
    localparam int RATIO_W     = 4;
    localparam int REG_W       = FAST_CODE_W + SLOW_CODE_W;

    typedef enum logic [0:0] {
        ST_COUNT = 1'b0,
        ST_PULSE = 1'b1
    } div_state_e;
endpackage

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
    import clkdiv_pkg::*;
#(
    parameter int W         = RATIO_W,
    parameter int RST_RATIO = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] next_ratio,
    output logic         en
);
    localparam div_state_e RST_STATE = (RST_RATIO == 1) ? ST_PULSE : ST_COUNT;

    div_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] ratio_q, ratio_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
            cnt_q   <= '0;
            ratio_q <= W'(RST_RATIO);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ratio_d = ratio_q;
        en      = 1'b0;
        unique case (state_q)
            ST_COUNT: begin
                cnt_d = cnt_q + W'(1);
                if (cnt_q + W'(1) == ratio_q - W'(1))
                    state_d = ST_PULSE;
            end
            ST_PULSE: begin
                en      = 1'b1;
                cnt_d   = '0;
                ratio_d = next_ratio;
                state_d = (next_ratio == W'(1)) ? ST_PULSE : ST_COUNT;
            end
            default: state_d = RST_STATE;
        endcase
    end
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int FW        = FAST_CODE_W,
    parameter int SW        = SLOW_CODE_W,
    parameter int W         = RATIO_W,
    parameter int RST_FAST  = 0,
    parameter int RST_SLOW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [FW+SW-1:0] wr_data,
    output logic [FW+SW-1:0] rd_data,
    output logic            err,
    output logic [W-1:0]    fast_ratio,
    output logic [W-1:0]    slow_ratio
);
    logic [FW-1:0] fast_q;
    logic [SW-1:0] slow_q;
    logic          err_q;
    logic [SW-1:0] wr_slow;
    logic [FW-1:0] wr_fast;

    assign wr_fast = wr_data[FW-1:0];
    assign wr_slow = wr_data[FW+SW-1:FW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= FW'(RST_FAST);
            slow_q <= SW'(RST_SLOW);
            err_q  <= 1'b0;
        end else if (wr_en) begin
            fast_q <= wr_fast;
            if (wr_slow == '0) err_q  <= 1'b1;
            else               slow_q <= wr_slow;
        end
    end

    assign rd_data    = {slow_q, fast_q};
    assign err        = err_q;
    assign fast_ratio = W'(1) << fast_q;
    assign slow_ratio = W'(slow_q);
endmodule

// File: rtl/clkdiv_dual.sv
module clkdiv_dual
    import clkdiv_pkg::*;
#(
    parameter int RST_FAST_CODE = 0,
    parameter int RST_SLOW_VAL  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             div_err,
    output logic             fast_en,
    output logic             slow_en
);
    localparam int RST_FAST_RATIO = 1 << RST_FAST_CODE;

    logic [RATIO_W-1:0] fast_ratio;
    logic [RATIO_W-1:0] slow_ratio;

    clkdiv_regs #(
        .FW(FAST_CODE_W), .SW(SLOW_CODE_W), .W(RATIO_W),
        .RST_FAST(RST_FAST_CODE), .RST_SLOW(RST_SLOW_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .err(div_err),
        .fast_ratio(fast_ratio), .slow_ratio(slow_ratio)
    );

    clkdiv_chan #(.W(RATIO_W), .RST_RATIO(RST_FAST_RATIO)) u_fast (
        .clk(clk), .rst_n(rst_n), .next_ratio(fast_ratio), .en(fast_en)
    );

    clkdiv_chan #(.W(RATIO_W), .RST_RATIO(RST_SLOW_VAL)) u_slow (
        .clk(clk), .rst_n(rst_n), .next_ratio(slow_ratio), .en(slow_en)
    );
endmodule

// File: rtl/clkdiv_dual_chk.sv
module clkdiv_dual_chk
    import clkdiv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             div_err,
    input logic             fast_en,
    input logic             slow_en
);
    logic [4:0] slow_gap, fast_gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_gap <= '0;
            fast_gap <= '0;
        end else begin
            slow_gap <= slow_en ? 5'd0 : slow_gap + 5'd1;
            fast_gap <= fast_en ? 5'd0 : fast_gap + 5'd1;
        end
    end

    // R2: slow strobe never stays low longer than a ratio-15 period
    a_r2_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
        slow_gap <= 5'd14);

    // R3: fast strobe never stays low longer than a ratio-8 period
    a_r3_fast_gap: assert property (@(posedge clk) disable iff (!rst_n)
        fast_gap <= 5'd7);

    a_r4_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[REG_W-1:FAST_CODE_W] != '0) |=> rd_data == $past(wr_data));

    a_r5_zero_keeps_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[REG_W-1:FAST_CODE_W] == '0) |=>
            (rd_data[REG_W-1:FAST_CODE_W] == $past(rd_data[REG_W-1:FAST_CODE_W])) && div_err);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |=> div_err);

    a_r6_err_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_err) |-> $past(wr_en && wr_data[REG_W-1:FAST_CODE_W] == '0));
endmodule

bind clkdiv_dual clkdiv_dual_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .div_err(div_err), .fast_en(fast_en), .slow_en(slow_en)
);

// File: tb/clkdiv_dual_tb.sv
module clkdiv_dual_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic [5:0] rd_data;
    logic       div_err, fast_en, slow_en;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    clkdiv_dual u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .div_err(div_err), .fast_en(fast_en), .slow_en(slow_en)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic en_of(input bit sel);
        return sel ? slow_en : fast_en;
    endfunction

    task automatic sync_pulse(input bit sel);
        do @(negedge clk); while (!en_of(sel));
    endtask

    task automatic next_gap(input bit sel, output int g);
        g = 0;
        do begin @(negedge clk); g++; end while (!en_of(sel));
    endtask

    task automatic do_write(input logic [3:0] slow, input logic [1:0] fast);
        wr_data = {slow, fast};
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        int g;
        check("R1 rd_data", rd_data, 6'h14);
        check("R1 div_err", div_err, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 fast_en steady", fast_en, 1);
        end
        sync_pulse(1'b1);
        next_gap(1'b1, g);
        check("R1 slow period 5", g, 5);
    endtask

    // R2/R4: program slow value and measure
    task automatic t_slow(input int n);
        int g;
        do_write(4'(n), 2'b00);
        check("R4 readback", rd_data, {4'(n), 2'b00});
        sync_pulse(1'b1);
        next_gap(1'b1, g);
        check("R2 slow period", g, n);
        next_gap(1'b1, g);
        check("R2 slow period repeat", g, n);
    endtask

    // R3/R8: program fast code, slow kept at 5
    task automatic t_fast(input logic [1:0] code, input int exp);
        int g;
        do_write(4'd5, code);
        sync_pulse(1'b0);
        next_gap(1'b0, g);
        check("R3 fast period", g, exp);
        sync_pulse(1'b1);
        next_gap(1'b1, g);
        check("R8 slow undisturbed", g, 5);
    endtask

    // R7: mid-period write keeps running period
    task automatic t_midwrite(input int old_n, input int new_n);
        int g;
        do_write(4'(old_n), 2'b00);
        sync_pulse(1'b1);
        sync_pulse(1'b1);
        @(negedge clk);
        g = 1;
        wr_data = {4'(new_n), 2'b00};
        wr_en   = 1'b1;
        @(negedge clk);
        g++;
        wr_en   = 1'b0;
        while (!slow_en) begin @(negedge clk); g++; end
        check("R7 running period kept", g, old_n);
        next_gap(1'b1, g);
        check("R7 new period applied", g, new_n);
    endtask

    // R5/R6: zero slow value refused, flag sticky
    task automatic t_zero();
        int g;
        do_write(4'd6, 2'b00);
        do_write(4'd0, 2'b10);
        check("R5 slow field kept", rd_data[5:2], 6);
        check("R5 fast field taken", rd_data[1:0], 2);
        check("R5 err set", div_err, 1);
        sync_pulse(1'b1);
        next_gap(1'b1, g);
        check("R5 slow period unchanged", g, 6);
        do_write(4'd3, 2'b00);
        check("R6 err stays", div_err, 1);
        repeat (5) @(negedge clk);
        check("R6 err stays later", div_err, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_slow(2);
        t_slow(6);
        t_slow(10);
        t_slow(15);
        t_slow(1);
        t_fast(2'b01, 2);
        t_fast(2'b10, 4);
        t_fast(2'b11, 8);
        t_fast(2'b00, 1);
        t_midwrite(10, 3);
        t_midwrite(4, 12);
        t_zero();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule